// File: doc/BRIEF.md
# Interrupt Level Recognizer

This block watches an encoded interrupt request arriving on three active-low pins. It decides when the processor core has to take an interrupt. The pins are inverted into a request level from 0 to 7, where 0 means no request. The pins are first synchronized. A new level is accepted only after it has held steady for two consecutive synchronized samples. The accepted level is then compared with the 3-bit priority mask taken from the processor status.

Levels 1 to 6 are judged by level comparison: a request is taken only while it is strictly above the mask. Level 7 is also taken on its rising transition, whatever the mask holds. A level 7 that stays asserted is therefore taken again if the mask later drops below 7. This is the one case where masks 6 and 7 differ.

A recognition raises `intPending` and latches the level on `intLevel`. Both hold until the core pulses `ack`. While a recognition is pending, no other request is taken, with one exception: a transition to level 7 replaces a pending lower level.

Top module: `irq_level_recognizer`

## Requirements
- R1: The request level is the bitwise inverse of the pins. Pins 111 mean no request, 100 mean level 3, 010 mean level 5, 001 mean level 6 and 000 mean level 7. A recognition reports that level number on `intLevel`.
- R2: A request of level 1 to 6 is recognized when it is strictly greater than `ipMask`.
- R3: A request at or below the mask causes no recognition, so masks 6 and 7 both block levels 1 to 6.
- R4: A request that stays held is recognized again once the mask is lowered below it, for example level 6 when the mask goes from 6 to 5.
- R5: A change of the request level from below 7 to 7 is recognized whatever the mask is, including mask 7.
- R6: A level-7 request held after a recognition under mask 7 causes no further recognition while the mask stays 7.
- R7: Lowering the mask from 7 to 6 while level 7 is still held causes a second level-7 recognition.
- R8: `intPending` and `intLevel` hold until a one-cycle `ack`, which clears both. `intLevel` reads 0 while nothing is pending. No other request is recognized while one is pending.
- R9: A transition to level 7 replaces a pending lower level: `intLevel` becomes 7 and `intPending` stays set.
- R10: A pin pattern is accepted only after two consecutive equal synchronized samples, so a pattern present for a single clock is never recognized.
- R11: When the mask already allows a request, `intPending` rises on the fifth rising clock edge after the pins change, and not before.
- R12: The level-7 transition detector re-arms only after the request falls below 7. A drop to level 6 followed by a return to 7 is recognized again under mask 7.
- R13: The synchronous reset `rst` clears the pending flag and the latched level, and sets the previous request level to 0. A level 7 held through reset is recognized again as a transition after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irqPinsN | input | 3 | Encoded interrupt request pins, active low, asynchronous |
| ipMask | input | 3 | Interrupt priority mask from the processor status |
| ack | input | 1 | One-cycle interrupt acknowledge or exception entry strobe |
| intPending | output | 1 | A recognized interrupt is waiting for the core |
| intLevel | output | 3 | Level of the pending recognition, 0 when none is pending |

## Verification
Some properties are checked by assertions on every cycle. A level above the mask is captured on the next edge. A request at or below the mask leaves the block idle. A level-7 transition always ends with level 7 pending. `ack` clears the pending state, and a pending recognition keeps its level until it is acknowledged. The accepted level changes only to a value that the synchronizer had presented steadily. Reset clears the pending state.

Other behaviour needs time and ordering that only the bench scenarios can show. These are the rejection of a one-cycle glitch, the exact five-edge latency, the re-arming of the edge detector after a drop to level 6, the second recognition when the mask falls from 7 to 6, and the recognition of a level 7 held through reset.

// File: rtl/irqrec_pkg.sv
package irqrec_pkg;

  // Strobes sent from the control module to the datapath.
  typedef struct packed {
    logic capture;  // latch the accepted request level
    logic forceTop; // latch the top (non-maskable) level
    logic clear;    // drop the latched level to zero
  } irqStrobe_t;

endpackage

// File: rtl/irqrec_datapath.sv
module irqrec_datapath
  import irqrec_pkg::*;
#(
  parameter int LVL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] irqPinsN,
  input  irqStrobe_t       strobe,
  output logic [LVL_W-1:0] reqLvl,
  output logic [LVL_W-1:0] prevLvl,
  output logic [LVL_W-1:0] pendLvl
);

  localparam int HIST_N = FILT_DEPTH - 1;
  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  logic [LVL_W-1:0] syncChain [SYNC_STAGES];
  logic [LVL_W-1:0] filtHist  [HIST_N];
  logic [HIST_N-1:0] eqVec;
  logic [LVL_W-1:0] syncOut;
  logic             stableNow;

  // Synchronizer chain on the raw pins. It resets to "no request" (all ones).
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) syncChain[0] <= '1;
        else     syncChain[0] <= irqPinsN;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) syncChain[s] <= '1;
        else     syncChain[s] <= syncChain[s-1];
      end
    end
  end

  assign syncOut = syncChain[SYNC_STAGES-1];

  // Sample history for the stability filter.
  for (genvar h = 0; h < HIST_N; h++) begin : g_hist
    if (h == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) filtHist[0] <= '1;
        else     filtHist[0] <= syncOut;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) filtHist[h] <= '1;
        else     filtHist[h] <= filtHist[h-1];
      end
    end
    assign eqVec[h] = (filtHist[h] == syncOut);
  end

  assign stableNow = &eqVec;

  // Accepted request level (inverse of the pins) and its one-cycle history.
  always_ff @(posedge clk) begin
    if (rst) begin
      reqLvl  <= '0;
      prevLvl <= '0;
    end else begin
      if (stableNow) reqLvl <= ~syncOut;
      prevLvl <= reqLvl;
    end
  end

  // Latched level of the pending recognition.
  always_ff @(posedge clk) begin
    if (rst)                 pendLvl <= '0;
    else if (strobe.forceTop) pendLvl <= TOP_LVL;
    else if (strobe.capture)  pendLvl <= reqLvl;
    else if (strobe.clear)    pendLvl <= '0;
  end

  AST_FILTERED_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !$stable(reqLvl) |-> ($past(syncOut) == ~reqLvl)); // R10

endmodule

// File: rtl/irqrec_control.sv
module irqrec_control
  import irqrec_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] ipMask,
  input  logic             ack,
  input  logic [LVL_W-1:0] reqLvl,
  input  logic [LVL_W-1:0] prevLvl,
  input  logic [LVL_W-1:0] pendLvl,
  output irqStrobe_t       strobe,
  output logic             intPending
);

  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  logic riseTop;
  logic levelHit;
  logic topHeld;

  // The edge detector fires only when the previous level was below top.
  assign riseTop  = (reqLvl == TOP_LVL) && (prevLvl != TOP_LVL);
  assign levelHit = (reqLvl > ipMask);
  assign topHeld  = intPending && (pendLvl == TOP_LVL) && !ack;

  always_comb begin
    strobe.forceTop = riseTop && !topHeld;
    strobe.clear    = ack && !strobe.forceTop;
    strobe.capture  = levelHit && !intPending && !ack && !strobe.forceTop;
  end

  always_ff @(posedge clk) begin
    if (rst)                                    intPending <= 1'b0;
    else if (strobe.forceTop || strobe.capture) intPending <= 1'b1;
    else if (strobe.clear)                      intPending <= 1'b0;
  end

  AST_LEVEL_HIT: assert property (@(posedge clk) disable iff (rst)
    (!intPending && !ack && reqLvl > ipMask) |=> (intPending && pendLvl == $past(reqLvl))); // R2
  AST_AT_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!intPending && reqLvl <= ipMask && !(reqLvl == TOP_LVL && prevLvl != TOP_LVL)) |=> !intPending); // R3
  AST_TOP_EDGE: assert property (@(posedge clk) disable iff (rst)
    (reqLvl == TOP_LVL && prevLvl != TOP_LVL) |=> (intPending && pendLvl == TOP_LVL)); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack && !(reqLvl == TOP_LVL && prevLvl != TOP_LVL)) |=> (!intPending && pendLvl == '0)); // R8
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (intPending && !ack && !(reqLvl == TOP_LVL && prevLvl != TOP_LVL)) |=> (intPending && $stable(pendLvl))); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!intPending && pendLvl == '0)); // R13

endmodule

// File: rtl/irq_level_recognizer.sv
module irq_level_recognizer #(
  parameter int LVL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] irqPinsN,
  input  logic [LVL_W-1:0] ipMask,
  input  logic             ack,
  output logic             intPending,
  output logic [LVL_W-1:0] intLevel
);

  irqrec_pkg::irqStrobe_t strobe;
  logic [LVL_W-1:0] reqLvl;
  logic [LVL_W-1:0] prevLvl;
  logic [LVL_W-1:0] pendLvl;

  irqrec_datapath #(
    .LVL_W(LVL_W), .SYNC_STAGES(SYNC_STAGES), .FILT_DEPTH(FILT_DEPTH)
  ) u_dp (
    .clk(clk), .rst(rst), .irqPinsN(irqPinsN), .strobe(strobe),
    .reqLvl(reqLvl), .prevLvl(prevLvl), .pendLvl(pendLvl)
  );

  irqrec_control #(.LVL_W(LVL_W)) u_ctl (
    .clk(clk), .rst(rst), .ipMask(ipMask), .ack(ack),
    .reqLvl(reqLvl), .prevLvl(prevLvl), .pendLvl(pendLvl),
    .strobe(strobe), .intPending(intPending)
  );

  assign intLevel = pendLvl;

endmodule

// File: tb/irq_level_recognizer_test.sv
module irq_level_recognizer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] irqPinsN = 3'b111;
  logic [2:0] ipMask = 3'd7;
  logic       ack = 1'b0;
  logic       intPending;
  logic [2:0] intLevel;

  int checks = 0;
  int errors = 0;
  int expectQ[$];
  logic       lastPend = 1'b0;
  logic [2:0] lastLvl = 3'd0;

  irq_level_recognizer uut (
    .clk(clk), .rst(rst), .irqPinsN(irqPinsN), .ipMask(ipMask),
    .ack(ack), .intPending(intPending), .intLevel(intLevel)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectRecog(input int lvl);
    expectQ.push_back(lvl);
  endtask

  task automatic pulseAck();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // Monitor: each new recognition (pending rises, or the level changes while pending).
  always @(negedge clk) begin
    if (rst) begin
      lastPend = 1'b0;
      lastLvl  = 3'd0;
    end else begin
      if (intPending && (!lastPend || intLevel != lastLvl)) begin
        if (expectQ.size() == 0) begin
          check(1'b0, "R8 unexpected recognition", int'(intLevel), 0);
        end else begin
          int exp;
          exp = expectQ.pop_front();
          check(intLevel == exp[2:0], "R1 recognized level", int'(intLevel), exp);
        end
      end
      lastPend = intPending;
      lastLvl  = intLevel;
    end
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog all requirements actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(3);
    check(!intPending, "R13 reset pending", int'(intPending), 0);
    check(intLevel == 3'd0, "R13 reset level", int'(intLevel), 0);
    rst = 1'b0;

    // R3: level 3 and level 6 under mask 6
    ipMask = 3'd6; irqPinsN = 3'b100; waitCyc(8);
    check(!intPending, "R3 level 3 under mask 6", int'(intPending), 0);
    irqPinsN = 3'b001; waitCyc(8);
    check(!intPending, "R3 level 6 under mask 6", int'(intPending), 0);
    // R4: lower the mask under the held level 6
    expectRecog(6); ipMask = 3'd5; waitCyc(2);
    check(intPending && intLevel == 3'd6, "R4 held level 6 after mask 5", int'(intLevel), 6);
    ipMask = 3'd6; pulseAck();
    check(!intPending && intLevel == 3'd0, "R8 ack clears", int'(intLevel), 0);
    irqPinsN = 3'b111; waitCyc(8);

    // R2: level 3 over mask 2
    ipMask = 3'd2; expectRecog(3); irqPinsN = 3'b100; waitCyc(8);
    check(intPending && intLevel == 3'd3, "R2 level 3 over mask 2", int'(intLevel), 3);
    // R8: level 5 is ignored while pending
    irqPinsN = 3'b010; waitCyc(8);
    check(intPending && intLevel == 3'd3, "R8 no new recognition while pending", int'(intLevel), 3);
    // R9: a transition to 7 replaces the pending level
    expectRecog(7); irqPinsN = 3'b000; waitCyc(8);
    check(intPending && intLevel == 3'd7, "R9 level 7 overwrites", int'(intLevel), 7);
    ipMask = 3'd7; pulseAck(); waitCyc(6);
    check(!intPending, "R6 held 7 under mask 7", int'(intPending), 0);
    // R7: mask 7 to 6 with level 7 held
    expectRecog(7); ipMask = 3'd6; waitCyc(2);
    check(intPending && intLevel == 3'd7, "R7 second level 7", int'(intLevel), 7);
    ipMask = 3'd7; pulseAck(); waitCyc(4);
    check(!intPending, "R6 no action after ack", int'(intPending), 0);

    // R12: drop to 6 and return to 7 under mask 7
    irqPinsN = 3'b001; waitCyc(8);
    check(!intPending, "R12 level 6 under mask 7", int'(intPending), 0);
    expectRecog(7); irqPinsN = 3'b000; waitCyc(8);
    check(intPending && intLevel == 3'd7, "R12 re-armed edge", int'(intLevel), 7);
    pulseAck();
    irqPinsN = 3'b111; waitCyc(8);

    // R10: a pattern present for one clock only
    ipMask = 3'd0;
    irqPinsN = 3'b011; @(negedge clk); irqPinsN = 3'b111; waitCyc(10);
    check(!intPending, "R10 one-cycle glitch ignored", int'(intPending), 0);

    // R11: five-edge latency
    expectRecog(5); irqPinsN = 3'b010; waitCyc(4);
    check(!intPending, "R11 not before fifth edge", int'(intPending), 0);
    waitCyc(1);
    check(intPending && intLevel == 3'd5, "R11 at fifth edge", int'(intLevel), 5);
    ipMask = 3'd7; pulseAck(); irqPinsN = 3'b111; waitCyc(8);

    // R5: a transition to 7 under mask 7
    expectRecog(7); irqPinsN = 3'b000; waitCyc(8);
    check(intPending && intLevel == 3'd7, "R5 level 7 under mask 7", int'(intLevel), 7);
    // R13: reset while level 7 is pending and held
    rst = 1'b1; waitCyc(2);
    check(!intPending && intLevel == 3'd0, "R13 reset clears", int'(intLevel), 0);
    expectRecog(7); rst = 1'b0; waitCyc(8);
    check(intPending && intLevel == 3'd7, "R13 held 7 after reset", int'(intLevel), 7);
    pulseAck(); irqPinsN = 3'b111; waitCyc(10);

    check(expectQ.size() == 0, "R1 missing recognitions", expectQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule